// File: doc/BRIEF.md
# Processor Status Flag Unit with Low-Byte Parity

This block holds the carry, parity and zero flags of a processor core. Each cycle an operation-class code says how the flags change. Computing operations take the carry and zero indications from the ALU and derive parity from the result word. A restore operation reloads the flags from a supplied flags word. A floating-point condition copy moves three of the four FPU condition bits onto the integer flags. Any other code leaves the flags as they are.

Parity is always taken from the least significant byte of the result, whatever the result width. The parity flag is 1 when that byte has an even number of ones. A branch request asks either "jump if parity" or "jump if no parity". The block answers it from the flags already held in the register, so an unordered floating-point compare can be detected with a jump-if-parity after the condition copy.

Top module: `status_flags`

## Requirements
- R1: While `rst_n` is low the flags register reads 0. The reset is asynchronous and active-low, and it is released synchronously to `clk`.
- R2: Parity depends only on bits 7..0 of `result`. Changing bits above bit 7 has no effect on the parity flag.
- R3: The parity flag is 1 when bits 7..0 of the result hold an even number of ones and 0 when they hold an odd number. A result of 0x1A gives 0 and a result of 0x0A gives 1.
- R4: For op codes 1 (arithmetic), 2 (compare), 3 (logical) and 4 (test), the next clock edge loads carry from `carry_in`, zero from `zero_in` and parity as in R3.
- R5: For op code 5 (restore), the next edge loads carry, parity and zero from bits 0, 2 and 6 of `restore_word`. All other bits of that word are ignored.
- R6: For op code 6 (FPU condition copy), the next edge loads `fpu_cond[0]` into carry, `fpu_cond[2]` into parity and `fpu_cond[3]` into zero. `fpu_cond[1]` is ignored.
- R7: For op code 0 (no flag effect) and the unused code 7, all flags keep their values.
- R8: `br_taken` is `br_req` AND (the parity flag when `br_neg`=0, or its inverse when `br_neg`=1). It is combinational from the registered flags, so an update in the same cycle only affects the branch decision from the next cycle on.
- R9: `flags` places carry at bit 0, parity at bit 2 and zero at bit 6. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Operation class code (0..7) |
| result | input | RES_W | ALU result word |
| carry_in | input | 1 | ALU carry-out |
| zero_in | input | 1 | ALU zero indication |
| restore_word | input | FLAG_W | Flags word for restore |
| fpu_cond | input | 4 | FPU condition bits C3..C0 |
| br_req | input | 1 | Parity branch request |
| br_neg | input | 1 | 0 = jump if parity, 1 = jump if no parity |
| flags | output | FLAG_W | Flags register |
| br_taken | output | 1 | Branch decision |

## Verification
The bench builds the block with RES_W = 12. This leaves four result bits above the parity byte, and the bench toggles them to show that they never reach the parity flag. FLAG_W stays at 8, so every restore word can set bits outside the three defined positions, and the bench checks that those bits still read 0. The unordered-compare path (C2 = 1 followed by a jump-if-parity) and the one-cycle lag of the branch decision behind a flag update are both checked with the same parameters.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ARITH   = 3'd1,
    OP_CMP     = 3'd2,
    OP_LOGIC   = 3'd3,
    OP_TEST    = 3'd4,
    OP_RESTORE = 3'd5,
    OP_FPUCOPY = 3'd6,
    OP_RSVD    = 3'd7
  } op_class_e;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int ZF_POS = 6;
  localparam int PAR_W  = 8;

  typedef struct packed {
    logic cf;
    logic pf;
    logic zf;
  } flag_set_t;
endpackage

// File: rtl/low_byte_parity.sv
module low_byte_parity #(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] word,
  output logic             even
);
  localparam int TAP_W = flag_pkg::PAR_W;

  logic [TAP_W-1:0] tap;
  logic [TAP_W:0]   chain;

  assign tap      = word[TAP_W-1:0];
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < TAP_W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ tap[i];
  end

  assign even = chain[TAP_W];
endmodule

// File: rtl/flag_next.sv
module flag_next #(
  parameter int FLAG_W = 8
) (
  input  logic [2:0]          op_class,
  input  flag_pkg::flag_set_t cur,
  input  logic                par_even,
  input  logic                carry_in,
  input  logic                zero_in,
  input  logic [FLAG_W-1:0]   restore_word,
  input  logic [3:0]          fpu_cond,
  output flag_pkg::flag_set_t nxt,
  output logic                load_en
);
  import flag_pkg::*;

  op_class_e op;
  assign op = op_class_e'(op_class);

  always_comb begin
    nxt     = cur;
    load_en = 1'b0;
    unique case (op)
      OP_ARITH, OP_CMP, OP_LOGIC, OP_TEST: begin
        nxt.cf  = carry_in;
        nxt.pf  = par_even;
        nxt.zf  = zero_in;
        load_en = 1'b1;
      end
      OP_RESTORE: begin
        nxt.cf  = restore_word[CF_POS];
        nxt.pf  = restore_word[PF_POS];
        nxt.zf  = restore_word[ZF_POS];
        load_en = 1'b1;
      end
      OP_FPUCOPY: begin
        nxt.cf  = fpu_cond[0];
        nxt.pf  = fpu_cond[2];
        nxt.zf  = fpu_cond[3];
        load_en = 1'b1;
      end
      default: begin
        nxt     = cur;
        load_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/parity_branch.sv
module parity_branch (
  input  logic pf,
  input  logic br_req,
  input  logic br_neg,
  output logic br_taken
);
  logic cond;
  assign cond     = br_neg ? ~pf : pf;
  assign br_taken = br_req & cond;
endmodule

// File: rtl/status_flags.sv
module status_flags #(
  parameter int RES_W  = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_class,
  input  logic [RES_W-1:0]  result,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic [FLAG_W-1:0] restore_word,
  input  logic [3:0]        fpu_cond,
  input  logic              br_req,
  input  logic              br_neg,
  output logic [FLAG_W-1:0] flags,
  output logic              br_taken
);
  import flag_pkg::*;

  flag_set_t cur_q, nxt_d;
  logic      par_even;
  logic      load_en;

  low_byte_parity #(.RES_W(RES_W)) u_par (
    .word (result),
    .even (par_even)
  );

  flag_next #(.FLAG_W(FLAG_W)) u_next (
    .op_class     (op_class),
    .cur          (cur_q),
    .par_even     (par_even),
    .carry_in     (carry_in),
    .zero_in      (zero_in),
    .restore_word (restore_word),
    .fpu_cond     (fpu_cond),
    .nxt          (nxt_d),
    .load_en      (load_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load_en) begin
      cur_q <= nxt_d;
    end
  end

  always_comb begin
    flags         = '0;
    flags[CF_POS] = cur_q.cf;
    flags[PF_POS] = cur_q.pf;
    flags[ZF_POS] = cur_q.zf;
  end

  parity_branch u_br (
    .pf       (cur_q.pf),
    .br_req   (br_req),
    .br_neg   (br_neg),
    .br_taken (br_taken)
  );
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk #(
  parameter int RES_W  = 16,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_class,
  input logic [RES_W-1:0]  result,
  input logic              carry_in,
  input logic              zero_in,
  input logic [FLAG_W-1:0] restore_word,
  input logic [3:0]        fpu_cond,
  input logic              br_req,
  input logic              br_neg,
  input logic [FLAG_W-1:0] flags,
  input logic              br_taken
);
  logic [FLAG_W-1:0] defined_mask;
  always_comb begin
    defined_mask    = '0;
    defined_mask[0] = 1'b1;
    defined_mask[2] = 1'b1;
    defined_mask[6] = 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (flags == '0);
  end

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~defined_mask) == '0);

  assert_compute_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class inside {3'd1, 3'd2, 3'd3, 3'd4}) |=>
      flags[2] == ($countones($past(result[7:0])) % 2 == 0));

  assert_compute_cz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class inside {3'd1, 3'd2, 3'd3, 3'd4}) |=>
      (flags[0] == $past(carry_in)) && (flags[6] == $past(zero_in)));

  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd5) |=>
      (flags[0] == $past(restore_word[0])) && (flags[2] == $past(restore_word[2]))
      && (flags[6] == $past(restore_word[6])));

  assert_fpu_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd6) |=>
      (flags[0] == $past(fpu_cond[0])) && (flags[2] == $past(fpu_cond[2]))
      && (flags[6] == $past(fpu_cond[3])));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd0 || op_class == 3'd7) |=> $stable(flags));

  assert_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken == (br_req && (flags[2] != br_neg)));
endmodule

bind status_flags status_flags_chk #(.RES_W(RES_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/status_flags_test.sv
module status_flags_test;
  localparam int RES_W  = 12;
  localparam int FLAG_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        op_class;
  logic [RES_W-1:0]  result;
  logic              carry_in, zero_in;
  logic [FLAG_W-1:0] restore_word;
  logic [3:0]        fpu_cond;
  logic              br_req, br_neg;
  logic [FLAG_W-1:0] flags;
  logic              br_taken;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  status_flags #(.RES_W(RES_W), .FLAG_W(FLAG_W)) uut (.*);

  function automatic logic [7:0] mk(logic c, logic p, logic z);
    logic [7:0] v = 8'h00;
    v[0] = c; v[2] = p; v[6] = z;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle();
    op_class = 3'd0; result = '0; carry_in = 0; zero_in = 0;
    restore_word = '0; fpu_cond = '0; br_req = 0; br_neg = 0;
  endtask

  // drive at negedge, sample 1 ns after following posedge
  task automatic step(logic [2:0] op);
    @(negedge clk);
    op_class = op;
    @(posedge clk);
    #1;
    op_class = 3'd0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    #1;
    chk("R1 async", 32'(flags), 32'h0);
    repeat (2) @(posedge clk);
    #1 chk("R1 held", 32'(flags), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", 32'(flags), 32'h0);
  endtask

  task automatic t_parity_examples();
    result = 12'h01A; carry_in = 0; zero_in = 0;
    step(3'd1);
    chk("R3 0x1A odd", 32'(flags), 32'(mk(0, 0, 0)));
    result = 12'h00A;
    step(3'd3);
    chk("R3 0x0A even", 32'(flags), 32'(mk(0, 1, 0)));
    result = 12'h000; zero_in = 1;
    step(3'd1);
    chk("R3 zero byte even", 32'(flags), 32'(mk(0, 1, 1)));
    result = 12'h0FF; zero_in = 0;
    step(3'd2);
    chk("R3 0xFF even", 32'(flags), 32'(mk(0, 1, 0)));
  endtask

  task automatic t_upper_ignored();
    result = 12'hF01; carry_in = 0; zero_in = 0;
    step(3'd1);
    chk("R2 upper bits set, low odd", 32'(flags), 32'(mk(0, 0, 0)));
    result = 12'h700;
    step(3'd1);
    chk("R2 upper bits odd count, low zero", 32'(flags), 32'(mk(0, 1, 0)));
  endtask

  task automatic t_compute_classes();
    for (int op = 1; op <= 4; op++) begin
      result = 12'h003; carry_in = op[0]; zero_in = op[1];
      step(3'(op));
      chk($sformatf("R4 op %0d", op), 32'(flags), 32'(mk(op[0], 1, op[1])));
    end
  endtask

  task automatic t_restore();
    restore_word = 8'hBB;
    step(3'd5);
    chk("R5 restore 0xBB", 32'(flags), 32'(mk(1, 0, 0)));
    chk("R9 undefined bits zero", 32'(flags & 8'hBA), 32'h0);
    restore_word = 8'h44;
    step(3'd5);
    chk("R5 restore 0x44", 32'(flags), 32'(mk(0, 1, 1)));
  endtask

  task automatic t_fpu_copy();
    fpu_cond = 4'b0010;
    step(3'd6);
    chk("R6 C1 ignored", 32'(flags), 32'(mk(0, 0, 0)));
    fpu_cond = 4'b1101;
    step(3'd6);
    chk("R6 C0 C2 C3 mapped", 32'(flags), 32'(mk(1, 1, 1)));
    br_req = 1; br_neg = 0; #1;
    chk("R6 unordered seen by jump-if-parity", 32'(br_taken), 32'h1);
    br_req = 0;
  endtask

  task automatic t_hold();
    result = 12'h001; carry_in = 0; zero_in = 0;
    restore_word = 8'h00; fpu_cond = 4'h0;
    step(3'd0);
    chk("R7 none holds", 32'(flags), 32'(mk(1, 1, 1)));
    step(3'd7);
    chk("R7 reserved holds", 32'(flags), 32'(mk(1, 1, 1)));
  endtask

  task automatic t_branch();
    br_req = 0; br_neg = 0; #1;
    chk("R8 no request", 32'(br_taken), 32'h0);
    br_req = 1; br_neg = 1; #1;
    chk("R8 no-parity with PF=1", 32'(br_taken), 32'h0);
    // same-cycle update: PF goes to 0, branch uses old value until edge
    @(negedge clk);
    result = 12'h001; op_class = 3'd1; br_neg = 0;
    #1 chk("R8 old PF before edge", 32'(br_taken), 32'h1);
    @(posedge clk); #1;
    op_class = 3'd0;
    chk("R8 jump-if-parity after update", 32'(br_taken), 32'h0);
    br_neg = 1; #1;
    chk("R8 no-parity with PF=0", 32'(br_taken), 32'h1);
    br_req = 0;
  endtask

  initial begin
    t_reset();
    t_parity_examples();
    t_upper_ignored();
    t_compute_classes();
    t_restore();
    t_fpu_copy();
    t_hold();
    t_branch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule